// File: doc/BRIEF.md
# Audio Output Clock and Mode Selector

This block sources the frame clock and bit clock for an audio serial output port and picks what drives the port's pins. It runs from a system clock that is either 512 or 768 times the output sample rate. In master mode it divides that clock down to a frame clock at the sample rate and a bit clock at 64 or 48 times the sample rate. The bit-clock rate depends on which system-clock ratio is selected.

In slave mode the two clock pins are released: their output enables go low, and the values seen on the pads are passed on to the rest of the port. In pass-through mode the input-side frame clock, bit clock and data lanes go straight to the output pins, whatever the other selects say, and the auxiliary output is held low. Outside pass-through mode the data lanes and the auxiliary line carry the converted data path, which is a placeholder input here.

Top module: `aoc_clkgen`

## Requirements
- R1: `rst_n` is a synchronous, active-low reset. At a rising edge of `clk` with `rst_n` low, the dividers clear. In master mode `out_frame` and `out_bitclk` are 0 after that edge.
- R2: With `ratio_sel` = 0 (512x clock) in master mode, let n be the number of `clk` edges since the divider last cleared, counted modulo 512. `out_bitclk` is 1 exactly when (n mod 8) >= 4, so the bit clock has period 8 and a 50% duty cycle.
- R3: With `ratio_sel` = 1 (768x clock) in master mode, n is counted modulo 768. `out_bitclk` is 1 exactly when (n mod 16) >= 8, so the bit clock has period 16 and a 50% duty cycle.
- R4: In master mode `out_frame` is 1 exactly when n >= 256 (512x) or n >= 384 (768x). Each frame holds 64 (512x) or 48 (768x) bit-clock periods.
- R5: Apart from a restart, `out_frame` changes only in a cycle where `out_bitclk` falls from 1 to 0.
- R6: In slave mode (`thru_en` = 0, `slave_sel` = 1), `frame_oe` and `bitclk_oe` are 0. `out_frame` equals `ext_frame` and `out_bitclk` equals `ext_bitclk`, combinationally.
- R7: When `thru_en` = 1, `out_frame`, `out_bitclk` and `out_data` equal `in_frame`, `in_bitclk` and `in_data` combinationally, both enables are 1, and `slave_sel` has no effect.
- R8: When `thru_en` = 1, `out_aux` is 0 whatever `conv_aux` is.
- R9: When `thru_en` = 0, `out_data` equals `conv_data` and `out_aux` equals `conv_aux`. In master mode (`thru_en` = 0, `slave_sel` = 0) both enables are 1.
- R10: At a `clk` edge where `ratio_sel` differs from its value at the previous edge, the dividers restart with n = 0. After that edge `out_frame` and `out_bitclk` are 0 in master mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, 512x or 768x the output sample rate |
| rst_n | input | 1 | Synchronous active-low reset |
| ratio_sel | input | 1 | 0 = 512x system clock, 1 = 768x |
| slave_sel | input | 1 | 1 = clocks supplied from outside, 0 = generated |
| thru_en | input | 1 | 1 = pass-through of input-side port |
| ext_frame | input | 1 | Frame clock seen on the pad in slave mode |
| ext_bitclk | input | 1 | Bit clock seen on the pad in slave mode |
| in_frame | input | 1 | Input-side frame clock |
| in_bitclk | input | 1 | Input-side bit clock |
| in_data | input | LANES | Input-side data lanes |
| conv_data | input | LANES | Converted data lanes (placeholder path) |
| conv_aux | input | 1 | Converted auxiliary line (placeholder path) |
| out_frame | output | 1 | Frame clock toward the output pin |
| out_bitclk | output | 1 | Bit clock toward the output pin |
| frame_oe | output | 1 | Drive enable for the frame-clock pin |
| bitclk_oe | output | 1 | Drive enable for the bit-clock pin |
| out_data | output | LANES | Output data lanes |
| out_aux | output | 1 | Auxiliary output, low in pass-through |

## Verification
The generated clocks are registered, so each reflects the count that was loaded at the most recent rising edge. The bench keeps its own edge count, updated on the same rising edges, and compares the outputs against it half a period later, at the falling edge plus one time step. A restart caused by a change of `ratio_sel` shows up at the first rising edge that samples the new value, and the check is made at the falling edge that follows. The mode multiplexer has no register, so the bench changes inputs at a falling edge and checks the outputs one time step later in the same half period.

// File: rtl/aoc_pkg.sv
package aoc_pkg;

   typedef enum logic [1:0] {
      MODE_MASTER = 2'd0,
      MODE_SLAVE  = 2'd1,
      MODE_THRU   = 2'd2
   } aoc_mode_e;

   // pass-through outranks the slave select
   function automatic aoc_mode_e decode_mode(input logic thru, input logic slave);
      if (thru)       return MODE_THRU;
      else if (slave) return MODE_SLAVE;
      else            return MODE_MASTER;
   endfunction

endpackage

// File: rtl/aoc_modcnt.sv
module aoc_modcnt #(
   parameter int W = 10
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic [W-1:0] last,
   output logic [W-1:0] cnt_nxt
);

   logic [W-1:0] cnt_q;

   // ">=" also folds a count that overshoots a newly smaller limit
   always_comb begin
      if (clr || cnt_q >= last) cnt_nxt = '0;
      else                      cnt_nxt = cnt_q + W'(1);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_nxt;
   end

endmodule

// File: rtl/aoc_divider.sv
module aoc_divider #(
   parameter int RATIO_LO = 512,
   parameter int RATIO_HI = 768,
   parameter int BDIV_LO  = 8,
   parameter int BDIV_HI  = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ratio_sel,
   output logic frame_o,
   output logic bit_o
);

   localparam int MAX_R = (RATIO_HI > RATIO_LO) ? RATIO_HI : RATIO_LO;
   localparam int MAX_B = (BDIV_HI > BDIV_LO) ? BDIV_HI : BDIV_LO;
   localparam int FW    = $clog2(MAX_R);
   localparam int BW    = $clog2(MAX_B) + 1;

   logic          ratio_q;
   logic          restart;
   logic [FW-1:0] f_last, f_half, f_nxt;
   logic [BW-1:0] b_last, b_half, b_nxt;
   logic          frame_q, bit_q;

   assign restart = (ratio_sel != ratio_q);

   always_comb begin
      if (ratio_sel) begin
         f_last = FW'(RATIO_HI - 1);
         f_half = FW'(RATIO_HI / 2);
         b_last = BW'(BDIV_HI - 1);
         b_half = BW'(BDIV_HI / 2);
      end else begin
         f_last = FW'(RATIO_LO - 1);
         f_half = FW'(RATIO_LO / 2);
         b_last = BW'(BDIV_LO - 1);
         b_half = BW'(BDIV_LO / 2);
      end
   end

   aoc_modcnt #(.W(FW)) u_frame_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (restart),
      .last    (f_last),
      .cnt_nxt (f_nxt)
   );

   aoc_modcnt #(.W(BW)) u_bit_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (restart),
      .last    (b_last),
      .cnt_nxt (b_nxt)
   );

   // outputs come straight from flops: no decode glitches reach the pins
   always_ff @(posedge clk) begin
      ratio_q <= ratio_sel;
      if (!rst_n) begin
         frame_q <= 1'b0;
         bit_q   <= 1'b0;
      end else begin
         frame_q <= (f_nxt >= f_half);
         bit_q   <= (b_nxt >= b_half);
      end
   end

   assign frame_o = frame_q;
   assign bit_o   = bit_q;

endmodule

// File: rtl/aoc_mode_mux.sv
module aoc_mode_mux
   import aoc_pkg::*;
#(
   parameter int LANES = 3
) (
   input  aoc_mode_e        mode,
   input  logic             gen_frame,
   input  logic             gen_bit,
   input  logic             ext_frame,
   input  logic             ext_bitclk,
   input  logic             in_frame,
   input  logic             in_bitclk,
   input  logic [LANES-1:0] in_data,
   input  logic [LANES-1:0] conv_data,
   input  logic             conv_aux,
   output logic             out_frame,
   output logic             out_bitclk,
   output logic             frame_oe,
   output logic             bitclk_oe,
   output logic [LANES-1:0] out_data,
   output logic             out_aux
);

   logic thru;
   assign thru = (mode == MODE_THRU);

   always_comb begin
      unique case (mode)
         MODE_THRU: begin
            out_frame  = in_frame;
            out_bitclk = in_bitclk;
            frame_oe   = 1'b1;
            bitclk_oe  = 1'b1;
         end
         MODE_SLAVE: begin
            out_frame  = ext_frame;
            out_bitclk = ext_bitclk;
            frame_oe   = 1'b0;
            bitclk_oe  = 1'b0;
         end
         default: begin
            out_frame  = gen_frame;
            out_bitclk = gen_bit;
            frame_oe   = 1'b1;
            bitclk_oe  = 1'b1;
         end
      endcase
   end

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      assign out_data[i] = thru ? in_data[i] : conv_data[i];
   end

   assign out_aux = thru ? 1'b0 : conv_aux;

endmodule

// File: rtl/aoc_clkgen.sv
module aoc_clkgen
   import aoc_pkg::*;
#(
   parameter int SYS_RATIO_LO = 512,
   parameter int SYS_RATIO_HI = 768,
   parameter int BIT_DIV_LO   = 8,
   parameter int BIT_DIV_HI   = 16,
   parameter int LANES        = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ratio_sel,
   input  logic             slave_sel,
   input  logic             thru_en,
   input  logic             ext_frame,
   input  logic             ext_bitclk,
   input  logic             in_frame,
   input  logic             in_bitclk,
   input  logic [LANES-1:0] in_data,
   input  logic [LANES-1:0] conv_data,
   input  logic             conv_aux,
   output logic             out_frame,
   output logic             out_bitclk,
   output logic             frame_oe,
   output logic             bitclk_oe,
   output logic [LANES-1:0] out_data,
   output logic             out_aux
);

   if (BIT_DIV_LO < 2 || BIT_DIV_LO % 2 != 0) begin : g_bad_bdiv_lo
      $error("BIT_DIV_LO must be even and at least 2");
   end
   if (BIT_DIV_HI < 2 || BIT_DIV_HI % 2 != 0) begin : g_bad_bdiv_hi
      $error("BIT_DIV_HI must be even and at least 2");
   end
   if (SYS_RATIO_LO % (2 * BIT_DIV_LO) != 0) begin : g_bad_ratio_lo
      $error("SYS_RATIO_LO must hold a whole, even number of bit periods");
   end
   if (SYS_RATIO_HI % (2 * BIT_DIV_HI) != 0) begin : g_bad_ratio_hi
      $error("SYS_RATIO_HI must hold a whole, even number of bit periods");
   end
   if (LANES < 1) begin : g_bad_lanes
      $error("LANES must be at least 1");
   end

   aoc_mode_e mode;
   logic      gen_frame;
   logic      gen_bit;

   assign mode = decode_mode(thru_en, slave_sel);

   aoc_divider #(
      .RATIO_LO (SYS_RATIO_LO),
      .RATIO_HI (SYS_RATIO_HI),
      .BDIV_LO  (BIT_DIV_LO),
      .BDIV_HI  (BIT_DIV_HI)
   ) u_div (
      .clk       (clk),
      .rst_n     (rst_n),
      .ratio_sel (ratio_sel),
      .frame_o   (gen_frame),
      .bit_o     (gen_bit)
   );

   aoc_mode_mux #(.LANES(LANES)) u_mux (
      .mode       (mode),
      .gen_frame  (gen_frame),
      .gen_bit    (gen_bit),
      .ext_frame  (ext_frame),
      .ext_bitclk (ext_bitclk),
      .in_frame   (in_frame),
      .in_bitclk  (in_bitclk),
      .in_data    (in_data),
      .conv_data  (conv_data),
      .conv_aux   (conv_aux),
      .out_frame  (out_frame),
      .out_bitclk (out_bitclk),
      .frame_oe   (frame_oe),
      .bitclk_oe  (bitclk_oe),
      .out_data   (out_data),
      .out_aux    (out_aux)
   );

endmodule

// File: rtl/aoc_clkgen_chk.sv
module aoc_clkgen_chk #(
   parameter int LANES = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             ratio_sel,
   input logic             slave_sel,
   input logic             thru_en,
   input logic             ext_frame,
   input logic             ext_bitclk,
   input logic             in_frame,
   input logic             in_bitclk,
   input logic [LANES-1:0] in_data,
   input logic [LANES-1:0] conv_data,
   input logic             conv_aux,
   input logic             out_frame,
   input logic             out_bitclk,
   input logic             frame_oe,
   input logic             bitclk_oe,
   input logic [LANES-1:0] out_data,
   input logic             out_aux,
   input logic             gen_frame,
   input logic             gen_bit
);

   logic ratio_d;
   logic restart;

   always_ff @(posedge clk) ratio_d <= ratio_sel;
   assign restart = (ratio_sel != ratio_d);

   assert_reset_low_R1: assert property (@(posedge clk)
      !rst_n |=> (!gen_frame && !gen_bit));

   assert_frame_on_bit_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(restart) && !$stable(gen_frame)) |-> $fell(gen_bit));

   assert_slave_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!thru_en && slave_sel) |->
         (!frame_oe && !bitclk_oe && out_frame == ext_frame && out_bitclk == ext_bitclk));

   assert_thru_pass_R7: assert property (@(posedge clk) disable iff (!rst_n)
      thru_en |-> (frame_oe && bitclk_oe && out_frame == in_frame &&
                   out_bitclk == in_bitclk && out_data == in_data));

   assert_thru_aux_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
      thru_en |-> !out_aux);

   assert_conv_path_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !thru_en |-> (out_data == conv_data && out_aux == conv_aux));

   assert_restart_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (!gen_frame && !gen_bit));

endmodule

bind aoc_clkgen aoc_clkgen_chk #(.LANES(LANES)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .ratio_sel  (ratio_sel),
   .slave_sel  (slave_sel),
   .thru_en    (thru_en),
   .ext_frame  (ext_frame),
   .ext_bitclk (ext_bitclk),
   .in_frame   (in_frame),
   .in_bitclk  (in_bitclk),
   .in_data    (in_data),
   .conv_data  (conv_data),
   .conv_aux   (conv_aux),
   .out_frame  (out_frame),
   .out_bitclk (out_bitclk),
   .frame_oe   (frame_oe),
   .bitclk_oe  (bitclk_oe),
   .out_data   (out_data),
   .out_aux    (out_aux),
   .gen_frame  (gen_frame),
   .gen_bit    (gen_bit)
);

// File: tb/aoc_clkgen_test.sv
module aoc_clkgen_test;

   localparam int CLK_PERIOD = 10;
   localparam int NVEC       = 8;

   // {thru,slave,ext_f,ext_b,in_f,in_b,in_d[3],conv[3],caux,
   //  use_model,exp_f,exp_b,exp_foe,exp_boe,exp_d[3],exp_aux,2'b00}
   localparam logic [23:0] VEC [NVEC] = '{
      24'b1_0_1_1_1_0_101_010_1_0_1_0_1_1_101_0_00,
      24'b1_1_0_0_0_1_011_100_1_0_0_1_1_1_011_0_00,
      24'b1_1_1_1_1_1_110_001_1_0_1_1_1_1_110_0_00,
      24'b0_1_1_0_0_1_111_010_1_0_1_0_0_0_010_1_00,
      24'b0_1_0_1_1_0_000_101_0_0_0_1_0_0_101_0_00,
      24'b0_1_1_1_0_0_001_110_1_0_1_1_0_0_110_1_00,
      24'b0_0_1_1_1_1_111_011_1_1_0_0_1_1_011_1_00,
      24'b0_0_0_0_0_0_000_100_0_1_0_0_1_1_100_0_00
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ratio_sel = 1'b0;
   logic       slave_sel = 1'b0;
   logic       thru_en = 1'b0;
   logic       ext_frame = 1'b0;
   logic       ext_bitclk = 1'b0;
   logic       in_frame = 1'b0;
   logic       in_bitclk = 1'b0;
   logic [2:0] in_data = '0;
   logic [2:0] conv_data = '0;
   logic       conv_aux = 1'b0;
   logic       out_frame, out_bitclk, frame_oe, bitclk_oe, out_aux;
   logic [2:0] out_data;

   int errors = 0;
   int checks = 0;
   int n = 0;
   logic ratio_prev = 1'b0;
   logic prev_f = 1'b0;
   logic prev_b = 1'b0;

   aoc_clkgen uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .ratio_sel  (ratio_sel),
      .slave_sel  (slave_sel),
      .thru_en    (thru_en),
      .ext_frame  (ext_frame),
      .ext_bitclk (ext_bitclk),
      .in_frame   (in_frame),
      .in_bitclk  (in_bitclk),
      .in_data    (in_data),
      .conv_data  (conv_data),
      .conv_aux   (conv_aux),
      .out_frame  (out_frame),
      .out_bitclk (out_bitclk),
      .frame_oe   (frame_oe),
      .bitclk_oe  (bitclk_oe),
      .out_data   (out_data),
      .out_aux    (out_aux)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   function automatic int frame_len(input logic r);
      return r ? 768 : 512;
   endfunction

   function automatic int bit_len(input logic r);
      return r ? 16 : 8;
   endfunction

   // reference edge count n, per the requirements
   always @(posedge clk) begin
      ratio_prev <= ratio_sel;
      if (!rst_n || ratio_sel != ratio_prev) n <= 0;
      else                                   n <= (n + 1) % frame_len(ratio_sel);
   end

   function automatic logic exp_bit();
      return (n % bit_len(ratio_sel)) >= bit_len(ratio_sel) / 2;
   endfunction

   function automatic logic exp_frame();
      return n >= frame_len(ratio_sel) / 2;
   endfunction

   task automatic check(input logic ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic step();
      @(negedge clk);
      #1;
   endtask

   // per-cycle comparison of the generated clocks against the model
   task automatic run_master(input int cycles, input string req);
      for (int c = 0; c < cycles; c++) begin
         step();
         check(out_bitclk == exp_bit(), req, out_bitclk, exp_bit());
         check(out_frame == exp_frame(), "R4", out_frame, exp_frame());
         if (out_frame != prev_f)
            check(prev_b && !out_bitclk, "R5", {prev_b, out_bitclk}, 2'b10);
         prev_f = out_frame;
         prev_b = out_bitclk;
      end
   endtask

   task automatic count_bits_per_frame(input int expected);
      int rises = 0;
      logic pb;
      while (!(out_frame && !prev_f)) begin
         prev_f = out_frame;
         step();
      end
      prev_f = out_frame;
      pb = out_bitclk;
      step();
      while (!(out_frame && !prev_f)) begin
         if (out_bitclk && !pb) rises++;
         pb = out_bitclk;
         prev_f = out_frame;
         step();
      end
      if (out_bitclk && !pb) rises++;
      prev_f = out_frame;
      prev_b = out_bitclk;
      check(rises == expected, "R4", rises, expected);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      // R1: reset state
      repeat (4) step();
      check(out_frame == 1'b0 && out_bitclk == 1'b0, "R1", {out_frame, out_bitclk}, 0);
      check(frame_oe && bitclk_oe, "R9", {frame_oe, bitclk_oe}, 2'b11);

      @(negedge clk);
      rst_n = 1'b1;
      prev_f = 1'b0;
      prev_b = 1'b0;

      // R2 and R4 with the 512x clock
      run_master(1100, "R2");
      count_bits_per_frame(64);

      // R10: ratio change restarts the dividers
      @(negedge clk);
      ratio_sel = 1'b1;
      step();
      check(out_frame == 1'b0 && out_bitclk == 1'b0, "R10", {out_frame, out_bitclk}, 0);
      check(n == 0, "R10", n, 0);
      prev_f = out_frame;
      prev_b = out_bitclk;

      // R3 and R4 with the 768x clock
      run_master(1600, "R3");
      count_bits_per_frame(48);

      // mode multiplexer table: R6, R7, R8, R9
      for (int v = 0; v < NVEC; v++) begin
         @(negedge clk);
         thru_en    = VEC[v][23];
         slave_sel  = VEC[v][22];
         ext_frame  = VEC[v][21];
         ext_bitclk = VEC[v][20];
         in_frame   = VEC[v][19];
         in_bitclk  = VEC[v][18];
         in_data    = VEC[v][17:15];
         conv_data  = VEC[v][14:12];
         conv_aux   = VEC[v][11];
         #1;
         if (VEC[v][10]) begin
            check(out_frame == exp_frame() && out_bitclk == exp_bit(), "R9",
                  {out_frame, out_bitclk}, {exp_frame(), exp_bit()});
         end else begin
            check(out_frame == VEC[v][9] && out_bitclk == VEC[v][8],
                  VEC[v][23] ? "R7" : "R6", {out_frame, out_bitclk}, VEC[v][9:8]);
         end
         check(frame_oe == VEC[v][7] && bitclk_oe == VEC[v][6],
               VEC[v][23] ? "R7" : (VEC[v][22] ? "R6" : "R9"),
               {frame_oe, bitclk_oe}, VEC[v][7:6]);
         check(out_data == VEC[v][5:3], VEC[v][23] ? "R7" : "R9", out_data, VEC[v][5:3]);
         check(out_aux == VEC[v][2], VEC[v][23] ? "R8" : "R9", out_aux, VEC[v][2]);
      end

      // R8: aux stays low in pass-through while conv_aux toggles
      @(negedge clk);
      thru_en = 1'b1;
      conv_aux = 1'b1;
      #1;
      check(out_aux == 1'b0, "R8", out_aux, 0);
      @(negedge clk);
      conv_aux = 1'b0;
      #1;
      check(out_aux == 1'b0, "R8", out_aux, 0);

      // R1: reset again, mid-frame, with the 768x clock in master mode
      @(negedge clk);
      thru_en = 1'b0;
      slave_sel = 1'b0;
      repeat (400) step();
      @(negedge clk);
      rst_n = 1'b0;
      step();
      check(out_frame == 1'b0 && out_bitclk == 1'b0, "R1", {out_frame, out_bitclk}, 0);
      @(negedge clk);
      rst_n = 1'b1;
      prev_f = 1'b0;
      prev_b = 1'b0;
      run_master(50, "R3");

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule